// File: doc/BRIEF.md
# PWM Event-Trigger Prescaler

This block thins out a stream of PWM timing events so that an ADC start-of-conversion request goes out only on every Nth event. It has two independent channels, A and B. Each channel receives a single-cycle event strobe, which is already chosen upstream. Each channel also has an enable, a 2-bit period N that software sets, a 2-bit event count that software can read, and a sticky status flag that software clears through a dedicated input.

Software sees the block through one 16-bit register with a plain write port and a continuous read port. The period fields can be written. The count fields are read-only and show how many events have arrived since the channel's last request. A period of zero freezes the channel completely. A request is still issued while the status flag from an earlier request is set. An event that arrives while the channel is disabled is still counted, and the count saturates at its maximum.

Top module: `soc_event_prescaler`

## Requirements
- R1: After reset, `rd_data` reads 0, and both `soc_pulse` and `soc_flag` are 0.
- R2: When a channel's period field is 0, its events leave its count unchanged and produce no pulse, whatever the enable is.
- R3: With a nonzero period P and the enable at 1, an event whose incremented count reaches P raises `soc_pulse` for one cycle and clears the count to 0. An event that leaves the count below P only increments it.
- R4: With the enable at 0 and a nonzero period, events increment the count, saturating at 3, and never produce a pulse. Once the channel is enabled, the next event whose saturated incremented count is at least P fires.
- R5: Register layout. Bits 9:8 are the A period and bits 11:10 the A count. Bits 13:12 are the B period and bits 15:14 the B count. Bits 7:0 always read 0. Channel A uses port bit 0 and channel B uses port bit 1.
- R6: A write updates only the two period fields. Bits written to the count fields or to bits 7:0 have no effect. A new period leaves the current count untouched.
- R7: `soc_flag` sets on every pulse and is cleared by `flag_clr`. A clear in the same cycle as a pulse leaves the flag set. A pulse still fires while the flag is set.
- R8: The channels are independent. Events on A and B in the same cycle are each processed in that cycle.
- R9: An event strobe and a write in the same cycle are handled as follows: the event is judged against the period held before the write. The updated count is readable after the sampling edge, and the pulse is high during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the prescale register |
| wr_data | input | 16 | Write data; only the period fields are taken |
| rd_data | output | 16 | Current register contents |
| evt_in | input | 2 | Single-cycle event strobes, bit 0 = A, bit 1 = B |
| trig_en | input | 2 | Per-channel pulse enable |
| flag_clr | input | 2 | Per-channel status flag clear |
| soc_pulse | output | 2 | Per-channel start-of-conversion pulse |
| soc_flag | output | 2 | Per-channel sticky status flag |

## Verification
An event or write driven in cycle k is sampled at the edge that ends cycle k. The new count, the pulse and the flag are all visible during cycle k+1, so every result is due exactly one cycle after its stimulus. The driver stamps each expected item with that due cycle, and the monitor compares the item at the falling edge of that cycle, well away from the edge where the outputs change. Expected values come from a requirement-level model in the bench, which judges each event against the period held before any same-cycle write.

// File: rtl/sep_pkg.sv
`timescale 1ns/1ps
package sep_pkg;

   localparam int SEP_CH_A = 0;
   localparam int SEP_CH_B = 1;

   // per-event decision of one channel
   typedef enum logic [1:0] {
      SEP_IDLE  = 2'd0,
      SEP_COUNT = 2'd1,
      SEP_FIRE  = 2'd2
   } sep_act_e;

   // field placement: period then count, one pair per channel
   function automatic int sep_prd_lsb(input int base, input int ch, input int w);
      return base + ch * 2 * w;
   endfunction

   function automatic int sep_cnt_lsb(input int base, input int ch, input int w);
      return base + ch * 2 * w + w;
   endfunction

endpackage

// File: rtl/sep_period_regs.sv
`timescale 1ns/1ps
module sep_period_regs
   import sep_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 2,
   parameter int DATA_W     = 16,
   parameter int FIELD_BASE = 8
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NUM_CH-1:0][CNT_W-1:0]  prd
);

   logic [NUM_CH-1:0][CNT_W-1:0] prd_q;
   logic                         unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_prd
      localparam int PL = sep_prd_lsb(FIELD_BASE, g, CNT_W);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prd_q[g] <= '0;
         end else if (wr_en) begin
            prd_q[g] <= wr_data[PL +: CNT_W];
         end
      end
   end

   assign prd = prd_q;

endmodule

// File: rtl/sep_channel.sv
`timescale 1ns/1ps
module sep_channel
   import sep_pkg::*;
#(
   parameter int CNT_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             en,
   input  logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] cnt,
   output logic             fire,
   output logic             pulse
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             pulse_q;
   sep_act_e         act;

   // saturating increment
   assign cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

   always_comb begin
      act = SEP_IDLE;
      if (evt && (prd != '0)) begin
         act = (en && (cnt_inc >= prd)) ? SEP_FIRE : SEP_COUNT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= (act == SEP_FIRE);
         case (act)
            SEP_FIRE:  cnt_q <= '0;
            SEP_COUNT: cnt_q <= cnt_inc;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt   = cnt_q;
   assign fire  = (act == SEP_FIRE);
   assign pulse = pulse_q;

endmodule

// File: rtl/sep_flag.sv
`timescale 1ns/1ps
module sep_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   // set dominates a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~clr) | set;
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/sep_readback.sv
`timescale 1ns/1ps
module sep_readback
   import sep_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 2,
   parameter int DATA_W     = 16,
   parameter int FIELD_BASE = 8
)(
   input  logic [NUM_CH-1:0][CNT_W-1:0] prd,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnt,
   output logic [DATA_W-1:0]            rd
);

   always_comb begin
      rd = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         rd[sep_prd_lsb(FIELD_BASE, ch, CNT_W) +: CNT_W] = prd[ch];
         rd[sep_cnt_lsb(FIELD_BASE, ch, CNT_W) +: CNT_W] = cnt[ch];
      end
   end

endmodule

// File: rtl/soc_event_prescaler.sv
`timescale 1ns/1ps
module soc_event_prescaler
   import sep_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 2,
   parameter int DATA_W     = 16,
   parameter int FIELD_BASE = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] evt_in,
   input  logic [NUM_CH-1:0] trig_en,
   input  logic [NUM_CH-1:0] flag_clr,
   output logic [NUM_CH-1:0] soc_pulse,
   output logic [NUM_CH-1:0] soc_flag
);

   localparam int FIELD_TOP = FIELD_BASE + NUM_CH * 2 * CNT_W;

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      $error("soc_event_prescaler: NUM_CH must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_w
      $error("soc_event_prescaler: CNT_W must be at least 1");
   end
   if (FIELD_TOP > DATA_W) begin : g_bad_fit
      $error("soc_event_prescaler: fields do not fit in DATA_W");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] prd;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt;
   logic [NUM_CH-1:0]            fire;

   sep_period_regs #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .prd(prd)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      sep_channel #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .evt(evt_in[g]), .en(trig_en[g]),
         .prd(prd[g]), .cnt(cnt[g]), .fire(fire[g]), .pulse(soc_pulse[g])
      );
      sep_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(fire[g]), .clr(flag_clr[g]),
         .flag(soc_flag[g])
      );
   end

   sep_readback #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE)
   ) u_rb (
      .prd(prd), .cnt(cnt), .rd(rd_data)
   );

endmodule

// File: rtl/sep_checker.sv
`timescale 1ns/1ps
module sep_checker
   import sep_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 2,
   parameter int DATA_W     = 16,
   parameter int FIELD_BASE = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [NUM_CH-1:0] evt_in,
   input logic [NUM_CH-1:0] trig_en,
   input logic [NUM_CH-1:0] flag_clr,
   input logic [NUM_CH-1:0] soc_pulse,
   input logic [NUM_CH-1:0] soc_flag
);

   logic unused_chk;
   assign unused_chk = wr_en ^ (^wr_data);

   if (FIELD_BASE > 0) begin : g_low
      AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[FIELD_BASE-1:0] == '0);                                   // R5
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int PL = sep_prd_lsb(FIELD_BASE, g, CNT_W);
      localparam int CL = sep_cnt_lsb(FIELD_BASE, g, CNT_W);

      AST_PRD0_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[PL +: CNT_W] == '0) |=> !soc_pulse[g]);                   // R2
      AST_PRD0_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[PL +: CNT_W] == '0) |=> $stable(rd_data[CL +: CNT_W]));   // R2
      AST_NO_EVT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         !evt_in[g] |=> !soc_pulse[g]);                                     // R3
      AST_PULSE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         soc_pulse[g] |-> (rd_data[CL +: CNT_W] == '0));                    // R3
      AST_DISABLED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         !trig_en[g] |=> !soc_pulse[g]);                                    // R4
      AST_CNT_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
         !evt_in[g] |=> $stable(rd_data[CL +: CNT_W]));                     // R6
      AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         soc_pulse[g] |-> soc_flag[g]);                                     // R7
      AST_FLAG_FALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(soc_flag[g]) |-> $past(flag_clr[g]));                        // R7
   end

endmodule

bind soc_event_prescaler sep_checker #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE)
) u_chk (.*);

// File: tb/sim_soc_event_prescaler.sv
`timescale 1ns/1ps
module sim_soc_event_prescaler;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  evt_in = '0, trig_en = '0, flag_clr = '0;
   logic [15:0] rd_data;
   logic [1:0]  soc_pulse, soc_flag;

   always #2.5 clk = ~clk;   // 200 MHz

   soc_event_prescaler u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .evt_in(evt_in), .trig_en(trig_en),
      .flag_clr(flag_clr), .soc_pulse(soc_pulse), .soc_flag(soc_flag)
   );

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int unsigned due;
      logic [1:0]  pulse;
      logic [1:0]  flag;
      logic [15:0] rd;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   errors = 0, checks = 0;
   bit   done = 0;

   // requirement-level model
   logic [1:0] m_prd [2];
   logic [1:0] m_cnt [2];
   logic [1:0] m_flg;

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: drive one cycle of stimulus and push the expected result
   task automatic step(input logic [1:0] ev, input logic [1:0] en,
                       input logic [1:0] clr, input logic wr,
                       input logic [15:0] wd, input string tag);
      exp_t e;
      @(negedge clk);
      evt_in = ev; trig_en = en; flag_clr = clr; wr_en = wr; wr_data = wd;
      for (int c = 0; c < 2; c++) begin
         logic [1:0] n;
         logic       f;
         f = 1'b0;
         if (ev[c] && m_prd[c] != 2'd0) begin
            n = (m_cnt[c] == 2'd3) ? 2'd3 : m_cnt[c] + 2'd1;
            if (en[c] && n >= m_prd[c]) begin
               f = 1'b1;
               m_cnt[c] = 2'd0;
            end else begin
               m_cnt[c] = n;
            end
         end
         e.pulse[c] = f;
         m_flg[c] = (m_flg[c] & ~clr[c]) | f;
      end
      if (wr) begin
         m_prd[0] = wd[9:8];
         m_prd[1] = wd[13:12];
      end
      e.flag = m_flg;
      e.rd   = {m_cnt[1], m_prd[1], m_cnt[0], m_prd[0], 8'h00};
      e.due  = cyc + 1;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // monitor: compare each item in the cycle it is due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag, "soc_pulse", {14'd0, soc_pulse}, {14'd0, e.pulse});
         chk(e.tag, "soc_flag",  {14'd0, soc_flag},  {14'd0, e.flag});
         chk(e.tag, "rd_data",   rd_data, e.rd);
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R9: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_prd[0] = 0; m_prd[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_flg = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rd_data", rd_data, 16'h0000);
      chk("R1", "soc_pulse", {14'd0, soc_pulse}, 16'h0);
      chk("R1", "soc_flag",  {14'd0, soc_flag},  16'h0);

      // R2: period 0, counting frozen
      repeat (3) step(2'b11, 2'b11, 2'b00, 1'b0, 16'h0, "R2");
      // R6: count and low bits written with ones are ignored; A P=1, B P=3
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'hFDFF, "R6");
      // R3/R8: simultaneous events, A every event, B on third
      step(2'b11, 2'b11, 2'b00, 1'b0, 16'h0, "R3");
      step(2'b11, 2'b11, 2'b00, 1'b0, 16'h0, "R3");
      step(2'b11, 2'b11, 2'b00, 1'b0, 16'h0, "R8");
      step(2'b10, 2'b11, 2'b00, 1'b0, 16'h0, "R8");
      // R6: new A period 2, B count kept
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'h3200, "R6");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R3");
      step(2'b00, 2'b11, 2'b00, 1'b0, 16'h0, "R3");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R3");
      // R4: disabled, saturate at 3, then enable
      repeat (4) step(2'b01, 2'b00, 2'b00, 1'b0, 16'h0, "R4");
      step(2'b01, 2'b01, 2'b00, 1'b0, 16'h0, "R4");
      // R7: clear, clear-with-pulse, pulse while set
      step(2'b00, 2'b11, 2'b11, 1'b0, 16'h0, "R7");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R7");
      step(2'b01, 2'b11, 2'b01, 1'b0, 16'h0, "R7");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R7");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R7");
      // R9: write and event together use the old period
      step(2'b01, 2'b11, 2'b00, 1'b1, 16'h3100, "R9");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R9");
      // R2: period forced to 0 with a count pending
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'h3200, "R2");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R2");
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'h3000, "R2");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R2");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R2");
      // R6: lowering the period below the count keeps the count
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'h3300, "R6");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R6");
      step(2'b00, 2'b11, 2'b00, 1'b1, 16'h3100, "R6");
      step(2'b01, 2'b11, 2'b00, 1'b0, 16'h0, "R6");
      repeat (3) step(2'b00, 2'b00, 2'b00, 1'b0, 16'h0, "R5");
      repeat (2) @(negedge clk);
      if (q.size() != 0) chk("R9", "queue_left", q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule